// File: doc/BRIEF.md
# Byte-Command I2C Master

This block is a single-master I2C controller that software steers one byte at a time. A byte-wide register bus reaches two registers. One is the data byte. The other is a control byte that selects the direction, an optional START before the byte and an optional STOP after it, and the acknowledge behaviour. Writing the control byte with its launch bit set runs one command. The block then drives the open-drain clock and data lines, sets its busy flag while the byte moves, and can raise a level interrupt when the command completes.

Software builds a whole transaction from a chain of such commands. A typical chain is an address byte with START, then data bytes, then a last byte that carries STOP. After a missing acknowledge, a pause command combined with STOP frees the bus without clocking any data. The bit rate comes from a quarter-period divider parameter. Each SCL half period lasts two quarter periods.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both lines are released (`scl_oe`=0, `sda_oe`=0), `irq` is 0, and the control and data registers read 0x00.
- R2: Address 0 selects the data register and address 1 the control register. Control bit positions: 0 stop, 1 start, 2 pause, 3 always reads 0, 4 acknowledge flag, 5 direction (1 = read), 6 interrupt enable, 7 launch/busy. When idle, the other bits read back as written.
- R3: Writing the control register with bit 7 set while idle launches a command. Bit 7 then reads 1 until the command has finished and reads 0 afterwards. The lines move only while a command runs.
- R4: With the start bit set, the command first produces a START (SDA falls while SCL is high). This also works while a transaction is already open, which gives a repeated START.
- R5: A write command (bit 5 = 0) shifts the data register out MSB first over 8 SCL pulses. SDA changes only while SCL is low, except inside START and STOP.
- R6: After a write command, bit 4 reads 1 if the slave pulled SDA low during the ninth SCL pulse and 0 if it did not. The data register keeps its value.
- R7: A read command (bit 5 = 1) samples 8 bits MSB first into the data register. During the ninth pulse the block pulls SDA low when bit 4 is 1 and releases SDA when bit 4 is 0. Bit 4 is left as written.
- R8: With the stop bit set, a STOP (SDA rises while SCL is high) follows the byte and both lines stay released. Without it, SCL is held low after the command.
- R9: A command with both pause and stop set produces only a STOP: no data pulses, and the data register and bit 4 do not change.
- R10: When bit 6 is set, `irq` goes to 1 when a command completes and stays at 1 until the next accepted control write. When bit 6 is clear, `irq` stays at 0.
- R11: Register writes that arrive while busy is set are ignored.
- R12: Every SCL high phase in which SDA stays stable lasts exactly 2*QTR_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 data, 1 control |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Level completion interrupt |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The bench builds the block with QTR_DIV = 4 and SYNC_STAGES = 2, so one byte takes about 150 cycles. At that cost all 256 byte values can be sent as writes and all 256 received as reads within one run. A bus slave model in the bench decodes START, STOP, data bits and acknowledges from the line levels. It counts every SCL high phase, so the half-period length is measured on every bit. The pause-after-NACK path, repeated START and writes during busy are each driven between the sweeps.

// File: rtl/i2c_bm_pkg.sv
`timescale 1ns/1ps
package i2c_bm_pkg;
   // control register bit positions (software-visible, fixed)
   localparam int CB_STOP  = 0;
   localparam int CB_START = 1;
   localparam int CB_PAUSE = 2;
   localparam int CB_ACK   = 4;
   localparam int CB_DIR   = 5;
   localparam int CB_IE    = 6;
   localparam int CB_BUSY  = 7;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_START,
      ENG_BIT,
      ENG_STOP,
      ENG_DONE
   } eng_state_t;
endpackage

// File: rtl/i2c_bm_tick.sv
`timescale 1ns/1ps
module i2c_bm_tick #(
   parameter int QTR_DIV = 250,
   parameter int DIV_W   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   if (QTR_DIV == 1) begin : g_direct
      assign tick = en;
   end else begin : g_count
      localparam logic [DIV_W-1:0] LAST = DIV_W'(QTR_DIV - 1);
      logic [DIV_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (!en || cnt == LAST) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end

      assign tick = en && (cnt == LAST);
   end
endmodule

// File: rtl/i2c_bm_sync.sv
`timescale 1ns/1ps
module i2c_bm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] chain;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '1;
         end else begin
            chain <= (chain << 1) | STAGES'(d);
         end
      end

      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/i2c_bm_engine.sv
`timescale 1ns/1ps
module i2c_bm_engine
   import i2c_bm_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              tick,
   input  logic              cmd_start,
   input  logic              cmd_stop,
   input  logic              cmd_pause,
   input  logic              cmd_read,
   input  logic              cmd_ack,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              sda_s,
   output logic              active,
   output logic              done,
   output logic              ack_seen,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              in_cond
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   eng_state_t        state;
   logic [1:0]        qtr;
   logic [CNT_W-1:0]  bitc;
   logic [BYTE_W-1:0] shreg;
   logic              abort_only;
   logic              ack_slot;
   logic              bit_drive;

   assign abort_only = cmd_pause && cmd_stop;
   assign ack_slot   = (bitc == LAST_BIT);

   // 1 = pull SDA low in the current bit slot
   always_comb begin
      if (cmd_read) begin
         bit_drive = ack_slot ? cmd_ack : 1'b0;
      end else begin
         bit_drive = ack_slot ? 1'b0 : !shreg[BYTE_W-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ENG_IDLE;
         qtr      <= '0;
         bitc     <= '0;
         shreg    <= '0;
         ack_seen <= 1'b0;
         scl_oe   <= 1'b0;
         sda_oe   <= 1'b0;
      end else begin
         case (state)
            ENG_IDLE: begin
               if (go) begin
                  shreg <= tx_byte;
                  qtr   <= '0;
                  bitc  <= '0;
                  if (cmd_start) begin
                     state <= ENG_START;
                  end else if (abort_only) begin
                     state <= ENG_STOP;
                  end else begin
                     state <= ENG_BIT;
                  end
               end
            end
            ENG_START: begin
               if (tick) begin
                  qtr <= qtr + 1'b1;
                  case (qtr)
                     2'd0: sda_oe <= 1'b0;
                     2'd1: scl_oe <= 1'b0;
                     2'd2: sda_oe <= 1'b1;
                     default: begin
                        scl_oe <= 1'b1;
                        state  <= abort_only ? ENG_STOP : ENG_BIT;
                     end
                  endcase
               end
            end
            ENG_BIT: begin
               if (tick) begin
                  qtr <= qtr + 1'b1;
                  case (qtr)
                     2'd0: sda_oe <= bit_drive;
                     2'd1: scl_oe <= 1'b0;
                     2'd2: begin
                        if (ack_slot) begin
                           ack_seen <= !sda_s;
                        end else begin
                           shreg <= {shreg[BYTE_W-2:0], sda_s};
                        end
                     end
                     default: begin
                        scl_oe <= 1'b1;
                        if (ack_slot) begin
                           state <= cmd_stop ? ENG_STOP : ENG_DONE;
                        end else begin
                           bitc <= bitc + 1'b1;
                        end
                     end
                  endcase
               end
            end
            ENG_STOP: begin
               if (tick) begin
                  qtr <= qtr + 1'b1;
                  case (qtr)
                     2'd0: sda_oe <= 1'b1;
                     2'd1: scl_oe <= 1'b0;
                     2'd2: sda_oe <= 1'b0;
                     default: state <= ENG_DONE;
                  endcase
               end
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   assign active  = (state == ENG_START) || (state == ENG_BIT) || (state == ENG_STOP);
   assign done    = (state == ENG_DONE);
   assign in_cond = (state == ENG_START) || (state == ENG_STOP);
   assign rx_byte = shreg;
endmodule

// File: rtl/i2c_bm_regs.sv
`timescale 1ns/1ps
module i2c_bm_regs
   import i2c_bm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_addr,
   input  logic       reg_we,
   input  logic [7:0] reg_wdata,
   input  logic       done,
   input  logic       ack_seen,
   input  logic [7:0] rx_byte,
   output logic [7:0] reg_rdata,
   output logic [7:0] data_q,
   output logic       f_stop,
   output logic       f_start,
   output logic       f_pause,
   output logic       f_ack,
   output logic       f_dir,
   output logic       f_ie,
   output logic       busy,
   output logic       go,
   output logic       irq
);
   logic accept;
   assign accept = reg_we && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         f_stop  <= 1'b0;
         f_start <= 1'b0;
         f_pause <= 1'b0;
         f_ack   <= 1'b0;
         f_dir   <= 1'b0;
         f_ie    <= 1'b0;
         busy    <= 1'b0;
         go      <= 1'b0;
         irq     <= 1'b0;
      end else begin
         go <= 1'b0;
         if (accept && !reg_addr) begin
            data_q <= reg_wdata;
         end
         if (accept && reg_addr) begin
            f_stop  <= reg_wdata[CB_STOP];
            f_start <= reg_wdata[CB_START];
            f_pause <= reg_wdata[CB_PAUSE];
            f_ack   <= reg_wdata[CB_ACK];
            f_dir   <= reg_wdata[CB_DIR];
            f_ie    <= reg_wdata[CB_IE];
            irq     <= 1'b0;
            if (reg_wdata[CB_BUSY]) begin
               busy <= 1'b1;
               go   <= 1'b1;
            end
         end
         if (done) begin
            busy <= 1'b0;
            irq  <= f_ie;
            if (!(f_pause && f_stop)) begin
               if (f_dir) begin
                  data_q <= rx_byte;
               end else begin
                  f_ack <= ack_seen;
               end
            end
         end
      end
   end

   always_comb begin
      if (reg_addr) begin
         reg_rdata = '0;
         reg_rdata[CB_STOP]  = f_stop;
         reg_rdata[CB_START] = f_start;
         reg_rdata[CB_PAUSE] = f_pause;
         reg_rdata[CB_ACK]   = f_ack;
         reg_rdata[CB_DIR]   = f_dir;
         reg_rdata[CB_IE]    = f_ie;
         reg_rdata[CB_BUSY]  = busy;
      end else begin
         reg_rdata = data_q;
      end
   end
endmodule

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master #(
   parameter int QTR_DIV     = 250,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_addr,
   input  logic       reg_we,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic       sda_in
);
   localparam int BYTE_W = 8;

   if (QTR_DIV < 1 || QTR_DIV >= (1 << DIV_W)) begin : g_bad_div
      $error("QTR_DIV must be in 1 .. 2**DIV_W-1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES >= 2 * QTR_DIV) begin : g_bad_sync
      $error("SYNC_STAGES must be below two quarter periods");
   end

   logic              busy, done, go, tick, active, in_cond;
   logic              f_stop, f_start, f_pause, f_ack, f_dir, f_ie;
   logic              ack_seen, sda_s;
   logic [BYTE_W-1:0] data_q, rx_byte;

   i2c_bm_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_we   (reg_we),
      .reg_wdata(reg_wdata),
      .done     (done),
      .ack_seen (ack_seen),
      .rx_byte  (rx_byte),
      .reg_rdata(reg_rdata),
      .data_q   (data_q),
      .f_stop   (f_stop),
      .f_start  (f_start),
      .f_pause  (f_pause),
      .f_ack    (f_ack),
      .f_dir    (f_dir),
      .f_ie     (f_ie),
      .busy     (busy),
      .go       (go),
      .irq      (irq)
   );

   i2c_bm_tick #(.QTR_DIV(QTR_DIV), .DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (active),
      .tick (tick)
   );

   i2c_bm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (sda_in),
      .q    (sda_s)
   );

   i2c_bm_engine #(.BYTE_W(BYTE_W)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .tick     (tick),
      .cmd_start(f_start),
      .cmd_stop (f_stop),
      .cmd_pause(f_pause),
      .cmd_read (f_dir),
      .cmd_ack  (f_ack),
      .tx_byte  (data_q),
      .sda_s    (sda_s),
      .active   (active),
      .done     (done),
      .ack_seen (ack_seen),
      .rx_byte  (rx_byte),
      .scl_oe   (scl_oe),
      .sda_oe   (sda_oe),
      .in_cond  (in_cond)
   );
endmodule

// File: rtl/i2c_bm_chk.sv
`timescale 1ns/1ps
module i2c_bm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_addr,
   input logic       reg_we,
   input logic [7:0] reg_wdata,
   input logic       busy,
   input logic       done,
   input logic       irq,
   input logic [7:0] data_q,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic       in_cond
);
   // R5
   sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> in_cond);

   // R3
   launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr && reg_wdata[7] && !busy) |=> busy);

   // R3
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> ($stable(scl_oe) && $stable(sda_oe)));

   // R10
   irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !busy);

   // R10
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr && !busy) |=> !irq);

   // R11
   busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && reg_we && !reg_addr) |=> (data_q == $past(data_q)));
endmodule

bind i2c_byte_master i2c_bm_chk u_chk (.*);

// File: tb/i2c_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
   localparam int QTR = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_addr = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq, scl_oe, sda_oe;
   logic       sda_l, scl_l, slv_pull;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #5 clk = !clk;

   i2c_byte_master #(.QTR_DIV(QTR), .DIV_W(16), .SYNC_STAGES(2)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_we   (reg_we),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .irq      (irq),
      .scl_oe   (scl_oe),
      .sda_oe   (sda_oe),
      .sda_in   (sda_l)
   );

   // ---------------- bus slave model ----------------
   logic       slv_rd = 1'b0;
   logic       slv_ack = 1'b0;
   logic [7:0] slv_tx = 8'h00;
   logic [7:0] sh = 8'h00;
   logic [7:0] got_byte = 8'h00;
   logic       got_ack = 1'b0;
   logic       rd_halt = 1'b0;
   int bitn = 0, drv_idx = 0, byte_cnt = 0, start_cnt = 0, stop_cnt = 0;

   assign scl_l = !scl_oe;
   assign sda_l = !(sda_oe || slv_pull);
   assign slv_pull = slv_rd ? (!rd_halt && drv_idx < 8 && !slv_tx[3'(7 - drv_idx)])
                            : (drv_idx == 8 && slv_ack);

   always @(negedge sda_l) if (scl_l) begin
      start_cnt++; bitn = 0; rd_halt = 1'b0;
   end
   always @(posedge sda_l) if (scl_l) stop_cnt++;
   always @(posedge scl_l) begin
      if (bitn < 8) begin
         sh = {sh[6:0], sda_l};
         bitn++;
      end else begin
         got_byte = sh; got_ack = !sda_l; byte_cnt++;
         if (slv_rd && sda_l) rd_halt = 1'b1;
         bitn = 0;
      end
   end
   always @(negedge scl_l) drv_idx = bitn;

   // ---------------- SCL high-phase monitor ----------------
   int hi_len = 0, hi_seen = 0, hi_bad = 0;
   logic hi_dirty = 1'b0, sda_prev = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_oe) begin
            if (hi_len > 0 && !hi_dirty) begin
               hi_seen++;
               if (hi_len != 2 * QTR) hi_bad++;
            end
            hi_len = 0; hi_dirty = 1'b0;
         end else begin
            if (hi_len > 0 && sda_l != sda_prev) hi_dirty = 1'b1;
            hi_len++;
         end
         sda_prev = sda_l;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic reg_wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic launch(input logic [7:0] ctl);
      logic [7:0] r;
      reg_wr(1'b1, ctl | 8'h80);
      reg_rd(1'b1, r);
      chk("R3 busy after launch", int'(r[7]), 1);
   endtask

   task automatic wait_idle();
      logic [7:0] r;
      r = 8'h80;
      for (int i = 0; i < 4000 && r[7]; i++) reg_rd(1'b1, r);
      chk("R3 busy cleared", int'(r[7]), 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [7:0] r, e;
      int bc0, sc0, sp0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      start_cnt = 0; stop_cnt = 0; byte_cnt = 0; bitn = 0; drv_idx = 0;

      // R1 reset state
      reg_rd(1'b1, r); chk("R1 control after reset", int'(r), 0);
      reg_rd(1'b0, r); chk("R1 data after reset", int'(r), 0);
      chk("R1 scl released", int'(scl_oe), 0);
      chk("R1 sda released", int'(sda_oe), 0);
      chk("R1 irq low", int'(irq), 0);

      // R2 field readback, bit 3 reads 0, no launch
      reg_wr(1'b1, 8'h7F);
      reg_rd(1'b1, r); chk("R2 control readback", int'(r), 'h77);
      chk("R2 no launch no lines", int'(scl_oe), 0);
      reg_wr(1'b1, 8'h00);

      // write sweep: every byte value, one transaction
      slv_ack = 1'b1; slv_rd = 1'b0;
      for (int v = 0; v < 256; v++) begin
         logic [7:0] ctl;
         ctl = 8'h00;
         if (v == 0) ctl[1] = 1'b1;
         if (v == 255) ctl[0] = 1'b1;
         ctl[6] = v[0];
         bc0 = byte_cnt;
         reg_wr(1'b0, v[7:0]);
         launch(ctl);
         if ((v & 15) == 5) begin
            reg_wr(1'b0, ~v[7:0]);   // R11: ignored while busy
            reg_wr(1'b1, 8'h24);
         end
         wait_idle();
         chk("R5 slave byte", int'(got_byte), v);
         chk("R5 one byte clocked", byte_cnt, bc0 + 1);
         reg_rd(1'b1, r);
         chk("R6 ack flag set", int'(r[4]), 1);
         chk("R11 ie kept", int'(r[6]), int'(v[0]));
         chk("R2 dir write", int'(r[5]), 0);
         chk("R10 irq level", int'(irq), int'(v[0]));
         reg_rd(1'b0, r);
         chk("R6 R11 data kept", int'(r), v);
         if (v != 255) chk("R8 scl held low", int'(scl_oe), 1);
         if (irq) begin
            reg_wr(1'b1, 8'h00);
            chk("R10 irq cleared", int'(irq), 0);
         end
      end
      chk("R4 one start", start_cnt, 1);
      chk("R8 one stop", stop_cnt, 1);
      chk("R8 scl free", int'(scl_oe), 0);
      chk("R8 sda free", int'(sda_oe), 0);

      // read sweep after start + repeated start
      sc0 = start_cnt; sp0 = stop_cnt;
      reg_wr(1'b0, 8'hA0); launch(8'h02); wait_idle();
      reg_wr(1'b0, 8'hA1); launch(8'h02); wait_idle();
      chk("R4 start and repeated start", start_cnt, sc0 + 2);
      chk("R4 no stop between", stop_cnt, sp0);
      slv_rd = 1'b1;
      for (int v = 0; v < 256; v++) begin
         logic last;
         last = (v == 255);
         e = {v[3:0], v[7:4]} ^ 8'h5A;
         slv_tx = e;
         reg_wr(1'b0, ~e);
         launch(last ? 8'h21 : 8'h30);
         wait_idle();
         reg_rd(1'b0, r);
         chk("R7 read byte", int'(r), int'(e));
         chk("R7 master ack bit", int'(got_ack), int'(!last));
         reg_rd(1'b1, r);
         chk("R7 ack flag kept", int'(r[4]), int'(!last));
      end
      slv_rd = 1'b0;
      chk("R8 stop after read", stop_cnt, sp0 + 1);

      // NACK then pause+stop
      slv_ack = 1'b0;
      bc0 = byte_cnt;
      reg_wr(1'b0, 8'hC3); launch(8'h02); wait_idle();
      reg_rd(1'b1, r);
      chk("R6 nack flag", int'(r[4]), 0);
      chk("R6 nack byte", int'(got_byte), 'hC3);
      reg_wr(1'b0, 8'h3C);
      sp0 = stop_cnt;
      launch(8'h45);
      wait_idle();
      chk("R9 stop only", stop_cnt, sp0 + 1);
      chk("R9 no data clocks", byte_cnt, bc0 + 1);
      reg_rd(1'b0, r); chk("R9 data unchanged", int'(r), 'h3C);
      reg_rd(1'b1, r); chk("R9 ack unchanged", int'(r[4]), 0);
      chk("R10 irq after abort", int'(irq), 1);
      chk("R9 lines free", int'(scl_oe | sda_oe), 0);

      // R12 SCL high time
      chk("R12 high phases off", hi_bad, 0);
      chk("R12 high phases seen", int'(hi_seen > 1000), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule